// File: doc/BRIEF.md
# Cascadable LCD Segment Column Driver Core

This block is the digital core of a column (segment) driver for a passive LCD panel. Display data arrives on a parallel bus that is either 8 or 4 bits wide. Each falling edge of a data clock stores one group of bits into a data latch that spans every column output. The fill can run from the first output toward the last, or the reverse. A falling edge on a line strobe copies the whole data latch into a line latch, and the line latch sets what the panel shows.

Each column output is a 2-bit drive-level code. The code depends on the line-latch bit, a frame-inversion input and a display-enable input. The analog level shifter that follows turns the code into a bias voltage.

Several drivers can share one data bus through a daisy chain of active-low enable links. The pin that acts as the link input and the pin that acts as the link output swap roles with the scan direction. Everything is sampled on a fast system clock, and falling edges of the data clock and line strobe are detected inside the block.

Top module: `seg_column_driver`

## Requirements
- R1: After reset the line latch and data latch hold zero, both link outputs are high, and with display enabled and frame inversion low every output shows code 3.
- R2: With `bus_narrow`=0 and `scan_rev`=0, the k-th accepted data-clock fall (k from 0) stores `din[b]` into output k*8+b, for b from 0 to 7.
- R3: With `bus_narrow`=1, each accepted fall stores only `din[3:0]`, into four consecutive outputs in the same way as R2. `din[7:4]` has no effect.
- R4: With `scan_rev`=1, the slot that R2 or R3 gives as p is instead written to output N_OUT-1-p.
- R5: A falling edge of `line_strobe` copies the data latch into the line latch. Data loaded after that edge does not reach the outputs until the next such edge.
- R6: With display enabled, an output's code is: line bit 1 and frame_inv 0 gives 1; line bit 1 and frame_inv 1 gives 0; line bit 0 and frame_inv 0 gives 3; line bit 0 and frame_inv 1 gives 2.
- R7: While `disp_on` is low, every output code is 0 and the line latch is held cleared. Data-clock falls still fill the data latch.
- R8: After `disp_on` returns high, outputs show the unselected codes (3 or 2) until the next line-strobe fall. After that fall they show the data latch.
- R9: Loading starts only on a data-clock fall while the active link input is low. Once started it continues to the last group (30 wide or 60 narrow for 240 outputs). Later falls are ignored until a line-strobe fall re-arms the block.
- R10: On loading the last group, the active link output goes low. It returns high at the next data-clock fall or line-strobe fall.
- R11: With `scan_rev`=0, the link input is `link_l_in` and the link output is `link_r_out` (`link_r_oe`=1, `link_l_oe`=0). With `scan_rev`=1 the roles are swapped. An inactive link output stays high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System sampling clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_narrow | input | 1 | 0: 8-bit bus, 1: 4-bit bus on din[3:0] |
| scan_rev | input | 1 | 0: fill from output 0 upward, 1: from the last output downward |
| shift_clk | input | 1 | Data clock, falling edge loads a group |
| line_strobe | input | 1 | Falling edge transfers the data latch to the line latch and re-arms |
| din | input | BUS_W | Display data bus |
| frame_inv | input | 1 | Frame inversion select |
| disp_on | input | 1 | Low forces all outputs to code 0 and clears the line latch |
| link_l_in | input | 1 | Left link pin, input side |
| link_l_out | output | 1 | Left link pin, output side |
| link_l_oe | output | 1 | Left link pin drives when high |
| link_r_in | input | 1 | Right link pin, input side |
| link_r_out | output | 1 | Right link pin, output side |
| link_r_oe | output | 1 | Right link pin drives when high |
| seg_level | output | 2*N_OUT | Drive-level code per output, output j at bits [2j+1:2j] |

## Verification
The bench builds the block at its default values, N_OUT=240 and BUS_W=8. It uses two instances, with the first one's right link output feeding the second one's left link input. The full output count puts the last group at index 29 for the wide bus and 59 for the narrow bus, so both ends of the group counter and both reversed mappings are exercised. In the cascade, one 60-group stream must split exactly at the 30-group boundary. The display-enable sequence covers a line-strobe fall while the display is off and the first fall after it is turned back on.

// File: rtl/seg_drv_pkg.sv
package seg_drv_pkg;

  typedef enum logic [1:0] {
    LVL_VSS = 2'd0,
    LVL_V0  = 2'd1,
    LVL_V12 = 2'd2,
    LVL_V43 = 2'd3
  } seg_lvl_e;

  // Rank of output j in fill order for a given direction.
  function automatic int unsigned slot_rank(input int unsigned n, input int unsigned j,
                                            input bit rev);
    return rev ? (n - 1 - j) : j;
  endfunction

  function automatic int unsigned slot_group(input int unsigned rank, input int unsigned w);
    return rank / w;
  endfunction

  function automatic int unsigned slot_bit(input int unsigned rank, input int unsigned w);
    return rank % w;
  endfunction

  // Drive level from display enable, line bit and frame inversion.
  function automatic seg_lvl_e drive_level(input logic on, input logic bit_v, input logic fr);
    seg_lvl_e lv;
    if (!on) begin
      lv = LVL_VSS;
    end else begin
      case ({bit_v, fr})
        2'b10:   lv = LVL_V0;
        2'b11:   lv = LVL_VSS;
        2'b00:   lv = LVL_V43;
        default: lv = LVL_V12;
      endcase
    end
    return lv;
  endfunction

endpackage

// File: rtl/fall_edge_detect.sv
module fall_edge_detect #(
  parameter int W = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] level_i,
  output logic [W-1:0] fall_o
);
  logic [W-1:0] level_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) level_q <= '0;
    else        level_q <= level_i;
  end

  assign fall_o = level_q & ~level_i;
endmodule

// File: rtl/fill_sequencer.sv
module fill_sequencer #(
  parameter int N_OUT = 240,
  parameter int BUS_W = 8,
  localparam int HALF_W = BUS_W / 2,
  localparam int IDX_W  = $clog2(N_OUT / HALF_W)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             shift_fall,
  input  logic             line_fall,
  input  logic             narrow,
  input  logic             chain_in_n,
  output logic             wr_en,
  output logic [IDX_W-1:0] grp_idx,
  output logic             carry_n
);
  localparam logic [IDX_W-1:0] LAST_WIDE   = IDX_W'(N_OUT / BUS_W - 1);
  localparam logic [IDX_W-1:0] LAST_NARROW = IDX_W'(N_OUT / HALF_W - 1);

  logic             busy_q, done_q;
  logic [IDX_W-1:0] last_idx;
  logic             last_load;

  assign last_idx  = narrow ? LAST_NARROW : LAST_WIDE;
  assign wr_en     = shift_fall & ~line_fall & ~done_q & (busy_q | ~chain_in_n);
  assign last_load = wr_en & (grp_idx == last_idx);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      grp_idx <= '0;
      busy_q  <= 1'b0;
      done_q  <= 1'b0;
      carry_n <= 1'b1;
    end else if (line_fall) begin
      grp_idx <= '0;
      busy_q  <= 1'b0;
      done_q  <= 1'b0;
      carry_n <= 1'b1;
    end else begin
      if (shift_fall) carry_n <= 1'b1;
      if (wr_en) begin
        busy_q <= 1'b1;
        if (last_load) begin
          done_q  <= 1'b1;
          carry_n <= 1'b0;
        end else begin
          grp_idx <= grp_idx + 1'b1;
        end
      end
    end
  end

  assert_grp_in_range_R9: assert property (@(posedge clk) disable iff (!rst_n)
    grp_idx <= LAST_NARROW);

  assert_carry_source_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(carry_n) |-> $past(last_load));

  assert_carry_width_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!carry_n && (shift_fall || line_fall)) |=> carry_n);

endmodule

// File: rtl/data_latch.sv
module data_latch
  import seg_drv_pkg::*;
#(
  parameter int N_OUT = 240,
  parameter int BUS_W = 8,
  localparam int HALF_W = BUS_W / 2,
  localparam int IDX_W  = $clog2(N_OUT / HALF_W),
  localparam int SEL_W  = $clog2(BUS_W)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic             narrow,
  input  logic             rev,
  input  logic [IDX_W-1:0] grp_idx,
  input  logic [BUS_W-1:0] din,
  output logic [N_OUT-1:0] data_o
);
  for (genvar j = 0; j < N_OUT; j++) begin : g_cell
    localparam int unsigned RF = slot_rank(N_OUT, j, 1'b0);
    localparam int unsigned RR = slot_rank(N_OUT, j, 1'b1);
    localparam logic [IDX_W-1:0] G_WF = IDX_W'(slot_group(RF, BUS_W));
    localparam logic [IDX_W-1:0] G_WR = IDX_W'(slot_group(RR, BUS_W));
    localparam logic [IDX_W-1:0] G_NF = IDX_W'(slot_group(RF, HALF_W));
    localparam logic [IDX_W-1:0] G_NR = IDX_W'(slot_group(RR, HALF_W));
    localparam logic [SEL_W-1:0] B_WF = SEL_W'(slot_bit(RF, BUS_W));
    localparam logic [SEL_W-1:0] B_WR = SEL_W'(slot_bit(RR, BUS_W));
    localparam logic [SEL_W-1:0] B_NF = SEL_W'(slot_bit(RF, HALF_W));
    localparam logic [SEL_W-1:0] B_NR = SEL_W'(slot_bit(RR, HALF_W));

    logic [IDX_W-1:0] sel_g;
    logic [SEL_W-1:0] sel_b;

    always_comb begin
      case ({narrow, rev})
        2'b00:   begin sel_g = G_WF; sel_b = B_WF; end
        2'b01:   begin sel_g = G_WR; sel_b = B_WR; end
        2'b10:   begin sel_g = G_NF; sel_b = B_NF; end
        default: begin sel_g = G_NR; sel_b = B_NR; end
      endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                        data_o[j] <= 1'b0;
      else if (wr_en && grp_idx == sel_g) data_o[j] <= din[sel_b];
    end
  end

  assert_hold_when_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(data_o));

endmodule

// File: rtl/line_stage.sv
module line_stage
  import seg_drv_pkg::*;
#(
  parameter int N_OUT = 240,
  localparam int LV_W = 2 * N_OUT
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             line_fall,
  input  logic             disp_on,
  input  logic             frame_inv,
  input  logic [N_OUT-1:0] data_i,
  output logic [N_OUT-1:0] line_o,
  output logic [LV_W-1:0]  level_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         line_o <= '0;
    else if (!disp_on)  line_o <= '0;
    else if (line_fall) line_o <= data_i;
  end

  for (genvar j = 0; j < N_OUT; j++) begin : g_lvl
    assign level_o[2*j +: 2] = drive_level(disp_on, line_o[j], frame_inv);
  end

  assert_off_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !disp_on |=> line_o == '0);

  assert_strobe_copies_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $past(line_fall && disp_on) |-> line_o == $past(data_i));

  assert_line_holds_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (disp_on && !line_fall) |=> $stable(line_o));

endmodule

// File: rtl/seg_column_driver.sv
module seg_column_driver
  import seg_drv_pkg::*;
#(
  parameter int N_OUT = 240,
  parameter int BUS_W = 8,
  localparam int HALF_W = BUS_W / 2,
  localparam int IDX_W  = $clog2(N_OUT / HALF_W)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               bus_narrow,
  input  logic               scan_rev,
  input  logic               shift_clk,
  input  logic               line_strobe,
  input  logic [BUS_W-1:0]   din,
  input  logic               frame_inv,
  input  logic               disp_on,
  input  logic               link_l_in,
  output logic               link_l_out,
  output logic               link_l_oe,
  input  logic               link_r_in,
  output logic               link_r_out,
  output logic               link_r_oe,
  output logic [2*N_OUT-1:0] seg_level
);
  logic [1:0]       falls;
  logic             shift_fall, line_fall;
  logic             chain_in_n, carry_n, wr_en;
  logic [IDX_W-1:0] grp_idx;
  logic [N_OUT-1:0] data_bits, line_bits;

  fall_edge_detect #(.W(2)) u_edges (
    .clk(clk), .rst_n(rst_n), .level_i({line_strobe, shift_clk}), .fall_o(falls)
  );
  assign shift_fall = falls[0];
  assign line_fall  = falls[1];

  // Link pin roles follow the scan direction.
  assign chain_in_n = scan_rev ? link_r_in : link_l_in;
  assign link_l_oe  = scan_rev;
  assign link_r_oe  = ~scan_rev;
  assign link_l_out = scan_rev ? carry_n : 1'b1;
  assign link_r_out = scan_rev ? 1'b1 : carry_n;

  fill_sequencer #(.N_OUT(N_OUT), .BUS_W(BUS_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .shift_fall(shift_fall), .line_fall(line_fall),
    .narrow(bus_narrow), .chain_in_n(chain_in_n), .wr_en(wr_en),
    .grp_idx(grp_idx), .carry_n(carry_n)
  );

  data_latch #(.N_OUT(N_OUT), .BUS_W(BUS_W)) u_data (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .narrow(bus_narrow), .rev(scan_rev),
    .grp_idx(grp_idx), .din(din), .data_o(data_bits)
  );

  line_stage #(.N_OUT(N_OUT)) u_line (
    .clk(clk), .rst_n(rst_n), .line_fall(line_fall), .disp_on(disp_on),
    .frame_inv(frame_inv), .data_i(data_bits), .line_o(line_bits), .level_o(seg_level)
  );

  assert_idle_link_high_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $changed(scan_rev) |-> (link_l_out || link_l_oe) && (link_r_out || link_r_oe));

  assert_write_needs_fall_R9: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> $past(shift_clk) && !shift_clk);

endmodule

// File: tb/seg_column_driver_test.sv
module seg_column_driver_test;
  localparam int N = 240;

  logic clk = 1'b0, rst_n = 1'b0;
  logic narrow = 0, rev = 0, xck = 0, lp = 0, fr = 0, on = 1;
  logic [7:0] din = '0;
  logic a_l_in = 0, a_r_in = 0;
  logic a_l_out, a_l_oe, a_r_out, a_r_oe, b_l_out, b_l_oe, b_r_out, b_r_oe;
  logic [2*N-1:0] a_lvl, b_lvl;

  logic [N-1:0] data_a = '0, line_a = '0, data_b = '0, line_b = '0;
  int n_checks = 0, n_bad = 0;

  always #4 clk = ~clk;

  seg_column_driver uut (
    .clk(clk), .rst_n(rst_n), .bus_narrow(narrow), .scan_rev(rev), .shift_clk(xck),
    .line_strobe(lp), .din(din), .frame_inv(fr), .disp_on(on),
    .link_l_in(a_l_in), .link_l_out(a_l_out), .link_l_oe(a_l_oe),
    .link_r_in(a_r_in), .link_r_out(a_r_out), .link_r_oe(a_r_oe), .seg_level(a_lvl));

  seg_column_driver peer (
    .clk(clk), .rst_n(rst_n), .bus_narrow(narrow), .scan_rev(rev), .shift_clk(xck),
    .line_strobe(lp), .din(din), .frame_inv(fr), .disp_on(on),
    .link_l_in(a_r_out), .link_l_out(b_l_out), .link_l_oe(b_l_oe),
    .link_r_in(1'b1), .link_r_out(b_r_out), .link_r_oe(b_r_oe), .seg_level(b_lvl));

  function automatic logic [1:0] want_code(logic en, logic b, logic f);
    if (!en) return 2'd0;
    if (b)   return f ? 2'd0 : 2'd1;
    return f ? 2'd2 : 2'd3;
  endfunction

  task automatic check(string req, int act, int exp);
    n_checks++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic check_levels(string req, logic [2*N-1:0] lv, logic [N-1:0] bits);
    int bad_j = -1;
    for (int j = N - 1; j >= 0; j--)
      if (lv[2*j +: 2] != want_code(on, bits[j], fr)) bad_j = j;
    n_checks++;
    if (bad_j >= 0) begin
      n_bad++;
      $display("FAIL %s output %0d actual=%0d expected=%0d", req, bad_j,
               lv[2*bad_j +: 2], want_code(on, bits[bad_j], fr));
    end
  endtask

  task automatic send_group(logic [7:0] v);
    din = v; xck = 1;
    repeat (2) @(negedge clk);
    xck = 0;
    repeat (2) @(negedge clk);
  endtask

  task automatic strobe();
    lp = 1;
    repeat (2) @(negedge clk);
    lp = 0;
    repeat (2) @(negedge clk);
    if (on) begin line_a = data_a; line_b = data_b; end
  endtask

  function automatic logic [7:0] pat_of(int g, int seed);
    return 8'((g * 29 + seed * 13 + 7) ^ (g << 3));
  endfunction

  // Load groups; group g goes to driver A for g < na, else to driver B.
  task automatic stream(int groups, int na, int seed);
    int w = narrow ? 4 : 8;
    for (int g = 0; g < groups; g++) begin
      logic [7:0] p = pat_of(g, seed);
      for (int b = 0; b < w; b++) begin
        int pos = ((g < na) ? g : g - na) * w + b;
        int j = rev ? N - 1 - pos : pos;
        if (g < na) data_a[j] = p[b]; else data_b[j] = p[b];
      end
      send_group(narrow ? {~p[7:4], p[3:0]} : p);
    end
  endtask

  task automatic test_reset();
    check_levels("R1 reset levels", a_lvl, '0);
    check("R1 left link idle", a_l_out, 1);
    check("R1 right link idle", a_r_out, 1);
    check("R11 left oe fwd", a_l_oe, 0);
    check("R11 right oe fwd", a_r_oe, 1);
  endtask

  task automatic test_fill(logic nar, logic rv, int seed, string req);
    narrow = nar; rev = rv; a_l_in = 0; a_r_in = 0;
    strobe();
    stream(narrow ? 60 : 30, 1000, seed);
    check_levels("R5 data held until strobe", a_lvl, line_a);
    check("R10 link out low after last group", rv ? a_l_out : a_r_out, 0);
    check("R11 idle link high", rv ? a_r_out : a_l_out, 1);
    check("R11 oe follows dir", {a_l_oe, a_r_oe}, rv ? 2 : 1);
    send_group(8'hA5);
    check("R10 link out back high", rv ? a_l_out : a_r_out, 1);
    strobe();
    check_levels(req, a_lvl, line_a);
  endtask

  task automatic test_fr();
    fr = 1;
    @(negedge clk);
    check_levels("R6 inverted frame", a_lvl, line_a);
    fr = 0;
    @(negedge clk);
    check_levels("R6 normal frame", a_lvl, line_a);
  endtask

  task automatic test_dispoff();
    narrow = 0; rev = 0; a_l_in = 0;
    on = 0; line_a = '0; line_b = '0;
    @(negedge clk);
    check_levels("R7 display off forces vss", a_lvl, line_a);
    strobe();
    stream(30, 1000, 9);
    check_levels("R7 still off after strobe and load", a_lvl, '0);
    on = 1;
    @(negedge clk);
    check_levels("R8 unselected after release", a_lvl, '0);
    strobe();
    check_levels("R8 data after first strobe, R7 load kept", a_lvl, line_a);
  endtask

  task automatic test_gate();
    narrow = 0; rev = 0; a_l_in = 1;
    strobe();
    for (int g = 0; g < 30; g++) send_group(8'hFF);
    check("R9 no link pulse when gated", a_r_out, 1);
    strobe();
    check_levels("R9 gated data ignored", a_lvl, line_a);
    a_l_in = 0;
  endtask

  task automatic test_cascade();
    narrow = 0; rev = 0; a_l_in = 0;
    strobe();
    stream(60, 30, 21);
    check("R10 second driver link out low", b_r_out, 0);
    strobe();
    check_levels("R10 cascade first driver", a_lvl, line_a);
    check_levels("R10 cascade second driver", b_lvl, line_b);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("test done: total=%0d bad=%0d", n_checks, n_bad);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    test_reset();
    test_fill(1'b0, 1'b0, 1, "R2 wide forward");
    test_fill(1'b1, 1'b0, 2, "R3 narrow forward");
    test_fill(1'b0, 1'b1, 3, "R4 wide reverse");
    test_fill(1'b1, 1'b1, 4, "R4 narrow reverse, R3");
    test_fr();
    test_dispoff();
    test_gate();
    test_cascade();
    $display("test done: total=%0d bad=%0d", n_checks, n_bad);
    $finish;
  end
endmodule